// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesizer with Compressed Wave Tables

This block is a direct digital synthesis core that produces one of four periodic waveforms as an unsigned sample word for an external DAC: sine, triangle, sawtooth, or a square wave with a programmable duty cycle. A 32-bit phase accumulator adds a host-programmed tuning word on every clock. The upper ten bits of the phase form a phase index, and that index is turned into the sample for the selected shape.

Table storage is kept small by relying on the structure of each shape. Only the first quarter of the sine is stored (256 magnitudes). The other quarters come from mirroring the address and complementing the magnitude. The triangle keeps only its rising half (512 entries), and the falling half reads that half backwards. The sawtooth is the phase index itself. The square is a compare of the phase index against a duty threshold. Together the two tables hold 768 entries where four full tables would hold 4096, which is 3/16 of that storage.

The host drives the tuning word, the waveform select and the duty threshold directly. Any change is taken on the next clock and leaves the phase untouched. At a 100 MHz clock one tuning-word step is 100e6/2^32 ≈ 0.0233 Hz, and a tuning word of 42 949 673 gives 1 MHz.

Top module: `dds_core`

## Requirements
- R1: On each clock out of reset the phase accumulator becomes (phase + tune_word) mod 2^32. Reset clears it to zero. The phase index k is phase bits [31:22].
- R2: With wave_sel = 0 (sine), sample = 511.5 + 511·sin(2π(k+0.5)/1024), rounded, to within 2 LSB. Only a 256-entry quarter-wave table is used.
- R3: With wave_sel = 1 (triangle), let j = k for k < 512 and j = 1023 − k otherwise. The sample is floor(j·1023/511), read from a 512-entry half-wave table.
- R4: With wave_sel = 2 (sawtooth), sample = k, with no table access.
- R5: With wave_sel = 3 (square), sample = 1023 while k < duty and 0 otherwise, and it takes no other value.
- R6: A duty of 0 holds the square output at 0. A duty of 1024 or more holds it at 1023.
- R7: The sample reflects the phase index, wave_sel and duty sampled two clock edges earlier for every waveform. The sample is 0 while reset is held.
- R8: Changing tune_word, wave_sel or duty never resets or jumps the phase. The accumulation continues from its present value.
- R9: A tune_word of 0 freezes the phase and therefore the sample. Any tune_word, including the 1 MHz value 42 949 673, steps the phase by exactly that amount per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tune_word | input | 32 | Phase increment per clock |
| wave_sel | input | 2 | 0 sine, 1 triangle, 2 sawtooth, 3 square |
| duty | input | 11 | Square threshold on the 10-bit phase index |
| sample_o | output | 10 | Unsigned sample word for the DAC |

## Verification
The cases hardest to reach are the boundaries of the mirrored tables. These are the quadrant edges where the sine address folds back and the magnitude complements, and the midpoint where the triangle reverses. Writing them directly to the outputs is impossible, and a random tuning word crosses them only rarely. The stimulus therefore uses a tuning word of exactly 2^22 so that the phase index steps by one per clock and sweeps all 1024 indices in turn, and 2^21 so that each index is held for two clocks. The bench compares every cycle against its own phase model. Other vectors switch waveform, tuning word and duty in mid-run, and apply a reset in mid-run, to confirm the two-edge alignment and the continuity of the phase.

// File: rtl/dds_pkg.sv
// Package: shared types for the DDS core.
// Assumes: the waveform select is a 2-bit field decoded in this order.
package dds_pkg;
    typedef enum logic [1:0] {
        WAVE_SINE   = 2'd0,
        WAVE_TRI    = 2'd1,
        WAVE_SAW    = 2'd2,
        WAVE_SQUARE = 2'd3
    } wave_e;
endpackage

// File: rtl/dds_phase_acc.sv
// Module: phase accumulator. It adds the tuning word every clock and exposes
// only the top IDX_W phase bits. Assumes IDX_W <= PHASE_W.
module dds_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int IDX_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_word,
    output logic [IDX_W-1:0]   phase_idx
);
    logic [PHASE_W-1:0] acc_q;

    // Wrap-around phase accumulation, cleared by reset (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + tune_word;
    end

    assign phase_idx = acc_q[PHASE_W-1 -: IDX_W];
endmodule

// File: rtl/dds_qsine_rom.sv
// Module: quarter-wave sine magnitude table with a registered read.
// Entry i holds round(AMP*sin((2i+1)*pi/(4*DEPTH))) with AMP = 2^DATA_W - 1.
// The table is filled at start-up by an integer rational sine approximation.
module dds_qsine_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int  DEPTH = 2 ** ADDR_W;
    localparam longint HALF = 4 * DEPTH;
    localparam longint AMP  = (longint'(1) << DATA_W) - 1;

    logic [DATA_W-1:0] mem [DEPTH];

    // Fill the table using a rational approximation on half-step angles.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            longint p, prod, num, den;
            p    = 2 * i + 1;
            prod = p * (HALF - p);
            num  = 16 * prod * AMP;
            den  = 5 * HALF * HALF - 4 * prod;
            mem[i] = DATA_W'((num + den / 2) / den);
        end
    end

    // Synchronous read.
    always_ff @(posedge clk) begin
        data_o <= mem[addr_i];
    end
endmodule

// File: rtl/dds_htri_rom.sv
// Module: rising half of a triangle with a registered read.
// Entry j holds floor(j*(2^DATA_W-1)/(DEPTH-1)), so it spans 0 to full scale.
module dds_htri_rom #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int     DEPTH = 2 ** ADDR_W;
    localparam longint FULL  = (longint'(1) << DATA_W) - 1;

    logic [DATA_W-1:0] mem [DEPTH];

    // Fill the ramp at start-up.
    initial begin
        for (int j = 0; j < DEPTH; j++) begin
            mem[j] = DATA_W'((longint'(j) * FULL) / (DEPTH - 1));
        end
    end

    // Synchronous read.
    always_ff @(posedge clk) begin
        data_o <= mem[addr_i];
    end
endmodule

// File: rtl/dds_core.sv
// Module: multi-waveform DDS top. Phase accumulator, then table address
// folding and registered table reads (stage 1), then shape selection and
// the output register (stage 2). Latency from the phase to the sample is two
// edges for every shape. Assumes SAMP_W == IDX_W so that the sawtooth is the
// phase index and the table depths match.
module dds_core #(
    parameter int PHASE_W = 32,
    parameter int IDX_W   = 10,
    parameter int SAMP_W  = 10,
    parameter int DUTY_W  = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic [1:0]         wave_sel,
    input  logic [DUTY_W-1:0]  duty,
    output logic [SAMP_W-1:0]  sample_o
);
    import dds_pkg::*;

    localparam int QA_W = IDX_W - 2;   // quarter-sine address width
    localparam int HA_W = IDX_W - 1;   // half-triangle address width

    logic [IDX_W-1:0]  phase_idx;
    logic [QA_W-1:0]   sin_addr;
    logic [HA_W-1:0]   tri_addr;
    logic [SAMP_W-2:0] sin_mag;
    logic [SAMP_W-1:0] tri_val;

    wave_e             s1_sel;
    logic [IDX_W-1:0]  s1_idx;
    logic              s1_neg;
    logic              s1_sq;
    logic [SAMP_W-1:0] sample_q;

    dds_phase_acc #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .phase_idx (phase_idx)
    );

    // Address folding: odd quarters and the second half read backwards.
    always_comb begin
        sin_addr = phase_idx[IDX_W-2] ? ~phase_idx[QA_W-1:0] : phase_idx[QA_W-1:0];
        tri_addr = phase_idx[IDX_W-1] ? ~phase_idx[HA_W-1:0] : phase_idx[HA_W-1:0];
    end

    dds_qsine_rom #(.ADDR_W(QA_W), .DATA_W(SAMP_W - 1)) u_sine (
        .clk    (clk),
        .addr_i (sin_addr),
        .data_o (sin_mag)
    );

    dds_htri_rom #(.ADDR_W(HA_W), .DATA_W(SAMP_W)) u_tri (
        .clk    (clk),
        .addr_i (tri_addr),
        .data_o (tri_val)
    );

    // Stage 1: register the select, index, sign and square decision alongside the table reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sel <= WAVE_SINE;
            s1_idx <= '0;
            s1_neg <= 1'b0;
            s1_sq  <= 1'b0;
        end else begin
            s1_sel <= wave_e'(wave_sel);
            s1_idx <= phase_idx;
            s1_neg <= phase_idx[IDX_W-1];
            s1_sq  <= {1'b0, phase_idx} < {{(DUTY_W > IDX_W ? DUTY_W - IDX_W : 1){1'b0}}, duty}[IDX_W:0] ? 1'b1 : 1'b0;
        end
    end

    // Stage 2: build the selected shape and register the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
        end else begin
            unique case (s1_sel)
                WAVE_SINE:   sample_q <= s1_neg ? {1'b0, ~sin_mag} : {1'b1, sin_mag};
                WAVE_TRI:    sample_q <= tri_val;
                WAVE_SAW:    sample_q <= s1_idx;
                WAVE_SQUARE: sample_q <= {SAMP_W{s1_sq}};
                default:     sample_q <= '0;
            endcase
        end
    end

    assign sample_o = sample_q;
endmodule

// File: rtl/dds_core_chk.sv
// Module: assertion checker for dds_core, attached by bind.
// Assumes a synchronous active-low reset and the select encoding of dds_pkg.
module dds_core_chk #(
    parameter int IDX_W  = 10,
    parameter int SAMP_W = 10,
    parameter int DUTY_W = IDX_W + 1,
    parameter int PHASE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PHASE_W-1:0] tune_word,
    input logic [1:0]         wave_sel,
    input logic [DUTY_W-1:0]  duty,
    input logic [SAMP_W-1:0]  sample_o,
    input dds_pkg::wave_e     s1_sel,
    input logic [IDX_W-1:0]   s1_idx,
    input logic [IDX_W-1:0]   phase_idx
);
    import dds_pkg::*;

    // R7: the output is cleared on the edge after a reset cycle.
    a_r7_reset_zero: assert property (@(posedge clk)
        !rst_n |=> sample_o == '0);

    // R4: the sawtooth output is the registered phase index.
    a_r4_saw_index: assert property (@(posedge clk) disable iff (!rst_n)
        s1_sel == WAVE_SAW |=> sample_o == SAMP_W'($past(s1_idx)));

    // R5: the square takes only the two rail values.
    a_r5_two_level: assert property (@(posedge clk) disable iff (!rst_n)
        s1_sel == WAVE_SQUARE |=> (sample_o == '0 || sample_o == '1));

    // R6: a zero threshold gives a low square two edges later.
    a_r6_duty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_sel == 2'd3 && duty == '0) |=> ##1 sample_o == '0);

    // R6: a threshold that covers the whole index range gives a high square.
    a_r6_duty_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_sel == 2'd3 && duty >= DUTY_W'(2 ** IDX_W)) |=> ##1 sample_o == '1);

    // R9: a zero tuning word holds the phase.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tune_word == '0 |=> $stable(phase_idx));
endmodule

bind dds_core dds_core_chk #(
    .IDX_W(IDX_W), .SAMP_W(SAMP_W), .DUTY_W(DUTY_W), .PHASE_W(PHASE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tune_word (tune_word),
    .wave_sel  (wave_sel),
    .duty      (duty),
    .sample_o  (sample_o),
    .s1_sel    (s1_sel),
    .s1_idx    (s1_idx),
    .phase_idx (phase_idx)
);

// File: tb/test_dds_core.sv
`timescale 1ns/1ps
// Bench: a vector table walked by one loop, then directed reset and continuity
// tests. A cycle model built from the requirements predicts every sample.
module test_dds_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tw = '0;
    logic [1:0]  sel = '0;
    logic [10:0] duty = '0;
    logic [9:0]  sample;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dds_core i_dds_core (
        .clk(clk), .rst_n(rst_n), .tune_word(tw),
        .wave_sel(sel), .duty(duty), .sample_o(sample)
    );

    // Expected sample for phase index k under select s and threshold d.
    function automatic int expect_val(int k, int s, int d);
        real th;
        int j;
        case (s)
            0: begin
                th = 2.0 * 3.14159265358979 * (real'(k) + 0.5) / 1024.0;
                return $rtoi(511.5 + 511.0 * $sin(th) + 0.5);
            end
            1: begin
                j = (k < 512) ? k : 1023 - k;
                return (j * 1023) / 511;
            end
            2: return k;
            default: return (k < d) ? 1023 : 0;
        endcase
    endfunction

    // Reference model: accumulator plus two pipeline stages.
    logic [31:0] m_acc;
    int m_k1, m_s1, m_d1, e_val, e_sel;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc <= '0; m_k1 <= 0; m_s1 <= 0; m_d1 <= 0; e_val <= 0; e_sel <= 2;
        end else begin
            m_acc <= m_acc + tw;
            m_k1  <= int'(m_acc[31:22]);
            m_s1  <= int'(sel);
            m_d1  <= int'(duty);
            e_val <= expect_val(m_k1, m_s1, m_d1);
            e_sel <= m_s1;
        end
    end

    // Run n cycles against the model and count the run as one check.
    task automatic run_model(int n, string tag);
        int errs = 0;
        for (int c = 0; c < n; c++) begin
            int diff, tol;
            @(posedge clk); @(negedge clk);
            tol  = (e_sel == 0) ? 2 : 0;
            diff = int'(sample) - e_val;
            if (diff > tol || diff < -tol) begin
                if (errs == 0)
                    $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, c, sample, e_val);
                errs++;
            end
        end
        n_chk++;
        if (errs != 0) n_bad++;
    endtask

    task automatic check_eq(int act, int exp, string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] tw;
        logic [10:0] duty;
        logic [15:0] ncyc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 32'h0040_0000, 11'd0,    16'd300},   // R4 ramp, one index per clock
        '{2'd0, 32'h0040_0000, 11'd0,    16'd1100},  // R2 full sweep of quadrants
        '{2'd1, 32'h0040_0000, 11'd0,    16'd1100},  // R3 full sweep, both halves
        '{2'd3, 32'h0040_0000, 11'd300,  16'd1100},  // R5 duty 300
        '{2'd0, 32'd42949673,  11'd0,    16'd400},   // R9 1 MHz tuning word
        '{2'd1, 32'h0123_4567, 11'd0,    16'd200},   // R3 odd step
        '{2'd3, 32'h0040_0000, 11'd0,    16'd200},   // R6 duty zero
        '{2'd3, 32'h0040_0000, 11'd1024, 16'd200},   // R6 duty full
        '{2'd0, 32'h0000_0000, 11'd0,    16'd50},    // R9 frozen phase
        '{2'd2, 32'hFFC0_0000, 11'd0,    16'd100},   // R1 wrap with a negative step
        '{2'd3, 32'h0080_0000, 11'd512,  16'd300},   // R5 half duty
        '{2'd1, 32'h0020_0000, 11'd0,    16'd2100}   // R3 each index held two clocks
    };

    function automatic string tag_of(int i);
        case (i)
            0, 9:  return "R4/R1";
            1:     return "R2";
            2, 5, 11: return "R3";
            3, 10: return "R5";
            6, 7:  return "R6";
            default: return "R9";
        endcase
    endfunction

    bit done = 0;

    initial begin
        // Reset state (R7).
        repeat (4) @(negedge clk);
        check_eq(int'(sample), 0, "R7 reset value");
        rst_n = 1'b1;

        // Vector table; each switch of inputs keeps phase continuity (R8).
        for (int i = 0; i < NV; i++) begin
            sel  = VEC[i].sel;
            tw   = VEC[i].tw;
            duty = VEC[i].duty;
            run_model(int'(VEC[i].ncyc), tag_of(i));
        end

        // Mid-run reset clears the output, then the phase restarts (R7, R1).
        sel = 2'd2; tw = 32'h0040_0000;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check_eq(int'(sample), 0, "R7 mid-run reset");
        rst_n = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
        check_eq(int'(sample), 1, "R1 phase restart");

        // Frequency change mid-ramp continues from the present phase (R8).
        run_model(20, "R8 before change");
        tw = 32'h0080_0000;
        run_model(40, "R8 after change");

        // Waveform switch takes effect exactly two edges later (R7).
        sel = 2'd3; duty = 11'd1024;
        @(posedge clk); @(negedge clk);
        check_eq(int'(sample) == 1023 ? 1 : 0, 0, "R7 not yet switched");
        @(posedge clk); @(negedge clk);
        check_eq(int'(sample), 1023, "R7 switched after two edges");
        run_model(30, "R7 alignment");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule